// File: doc/BRIEF.md
# Modem Control and Status Logic

This block is the modem-handshake part of a 16550-style serial controller. It holds the five-bit control byte that drives the data-terminal-ready, request-to-send and two general-purpose outputs. It also selects an internal loopback mode. Next to it sits the status byte. Its upper half mirrors the four incoming handshake lines: clear-to-send, data-set-ready, carrier-detect and ring. Its lower half collects sticky change flags, which the interrupt logic uses through a single summary output.

Software writes the control byte through a write strobe and reads the status byte with a read strobe. The read strobe consumes the change flags. The incoming lines are taken as already synchronized and are sampled on every clock edge.

In loopback the status half no longer looks at the external lines. Instead it takes its line states from the control bits themselves. The external outputs are then parked at their inactive level, so a self-test causes no traffic on the cable.

Top module: `modem_ctl_status`

## Requirements
- R1: After reset `ctl_q` is 8'h08 (only the OUT2 bit set), `stat_q` is 8'hB0 (carrier, data-set-ready and clear-to-send high, ring low, no change flags), `out2_o` is 1, `dtr_o`, `rts_o`, `out1_o` are 0 and `delta_o` is 0.
- R2: A control write stores `ctl_wdata[4:0]` (bit 4 loopback, bit 3 OUT2, bit 2 OUT1, bit 1 RTS, bit 0 DTR) one clock later; `ctl_q[7:5]` always reads 0 whatever was written there.
- R3: Outside loopback, `dtr_o`, `rts_o`, `out1_o` and `out2_o` equal control bits 0, 1, 2 and 3 respectively (1 = asserted).
- R4: Outside loopback, one clock after the line inputs are sampled, `stat_q[7]` shows carrier, `stat_q[6]` ring, `stat_q[5]` data-set-ready and `stat_q[4]` clear-to-send.
- R5: A change in either direction of clear-to-send, data-set-ready or carrier sets `stat_q[0]`, `stat_q[1]` or `stat_q[3]` respectively, in the same cycle the new line state appears; a set flag stays set until a status read.
- R6: `stat_q[2]` is set only when the ring state goes from 1 to 0; a rising ring state leaves it unchanged.
- R7: A status read (`stat_rd` high for one clock) clears `stat_q[3:0]` after that clock and leaves `stat_q[7:4]` unchanged.
- R8: A line change that is sampled in the same clock as a status read leaves its own change flag set after that clock. The other flags are still cleared.
- R9: In loopback (control bit 4), the status line bits read OUT2 as carrier, OUT1 as ring, DTR as data-set-ready and RTS as clear-to-send, two clocks after the control write. The external line inputs have no effect on `stat_q`.
- R10: In loopback, `dtr_o`, `rts_o`, `out1_o` and `out2_o` are all 0.
- R11: `delta_o` is 1 exactly when any of `stat_q[3:0]` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| stat_rd | input | 1 | Status byte read strobe (clears change flags) |
| cts_i | input | 1 | Clear-to-send line, synchronized, 1 = asserted |
| dsr_i | input | 1 | Data-set-ready line, synchronized |
| dcd_i | input | 1 | Carrier-detect line, synchronized |
| ri_i | input | 1 | Ring line, synchronized |
| ctl_q | output | 8 | Control byte readback |
| stat_q | output | 8 | Status byte: line states 7:4, change flags 3:0 |
| dtr_o | output | 1 | Data-terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | General-purpose output 1 |
| out2_o | output | 1 | General-purpose output 2 |
| delta_o | output | 1 | Any change flag set, to interrupt logic |

## Verification
Each handshake line is toggled on its own in both directions. This shows that every line reaches its own status bit and its own change flag, and that the flags do not spill into each other. The ring line is taken up and then down, which separates a plain difference detector from the trailing-edge rule. A read strobe is given once on quiet lines and once in the same clock as a line change, which separates a clear that wins from a new change that wins. In loopback, several control patterns are written and the external lines are toggled. This shows the bit remapping, proves that the external inputs are ignored, and checks that the trailing-edge rule also applies to the looped ring bit.

// File: rtl/modem_ctl_status.sv
module modem_ctl_status #(
  parameter logic [4:0] CTL_RST  = 5'b01000,
  parameter logic [3:0] LINE_RST = 4'b1011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       stat_rd,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       dcd_i,
  input  logic       ri_i,
  output logic [7:0] ctl_q,
  output logic [7:0] stat_q,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       delta_o
);

  logic [4:0] ctl_r;
  logic [3:0] line_r;   // {dcd, ri, dsr, cts}
  logic [3:0] chg_r;    // {d_dcd, te_ri, d_dsr, d_cts}
  logic [3:0] line_nx;
  logic [3:0] chg_new;
  logic       loop;

  assign loop = ctl_r[4];

  assign line_nx = loop ? {ctl_r[3], ctl_r[2], ctl_r[0], ctl_r[1]}
                        : {dcd_i, ri_i, dsr_i, cts_i};

  assign chg_new = {line_nx[3] ^ line_r[3],
                    line_r[2] & ~line_nx[2],
                    line_nx[1] ^ line_r[1],
                    line_nx[0] ^ line_r[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_r  <= CTL_RST;
      line_r <= LINE_RST;
      chg_r  <= '0;
    end else begin
      if (ctl_we) ctl_r <= ctl_wdata[4:0];
      line_r <= line_nx;
      chg_r  <= (stat_rd ? 4'b0000 : chg_r) | chg_new;
    end
  end

  assign ctl_q   = {3'b000, ctl_r};
  assign stat_q  = {line_r, chg_r};
  assign dtr_o   = ~loop & ctl_r[0];
  assign rts_o   = ~loop & ctl_r[1];
  assign out1_o  = ~loop & ctl_r[2];
  assign out2_o  = ~loop & ctl_r[3];
  assign delta_o = |chg_r;

endmodule

module modem_ctl_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_rd,
  input logic [7:0] ctl_q,
  input logic [7:0] stat_q,
  input logic       dtr_o,
  input logic       rts_o,
  input logic       out1_o,
  input logic       out2_o
);

  // R10
  loop_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[4] |-> !(dtr_o | rts_o | out1_o | out2_o));

  // R5
  cts_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[4] != $past(stat_q[4])) |-> stat_q[0]);

  // R6
  ri_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_q[6]) && !$past(stat_q[2])) |-> !stat_q[2]);

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_rd) && $stable(stat_q[7:4])) |-> (stat_q[3:0] == 4'b0000));

endmodule

bind modem_ctl_status modem_ctl_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .ctl_q(ctl_q), .stat_q(stat_q),
  .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o)
);

// File: tb/test_modem_ctl_status.sv
module test_modem_ctl_status;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       ctl_we = 0;
  logic [7:0] ctl_wdata = '0;
  logic       stat_rd = 0;
  logic       cts_i = 1, dsr_i = 1, dcd_i = 1, ri_i = 0;
  logic [7:0] ctl_q, stat_q;
  logic       dtr_o, rts_o, out1_o, out2_o, delta_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  modem_ctl_status i_modem_ctl_status (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .stat_rd(stat_rd), .cts_i(cts_i), .dsr_i(dsr_i), .dcd_i(dcd_i), .ri_i(ri_i),
    .ctl_q(ctl_q), .stat_q(stat_q), .dtr_o(dtr_o), .rts_o(rts_o),
    .out1_o(out1_o), .out2_o(out2_o), .delta_o(delta_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] pins();
    return {4'b0, out2_o, out1_o, rts_o, dtr_o};
  endfunction

  task automatic write_ctl(input logic [7:0] v);
    ctl_wdata = v; ctl_we = 1;
    step();
    ctl_we = 0;
  endtask

  task automatic read_stat();
    stat_rd = 1;
    step();
    stat_rd = 0;
  endtask

  task automatic t_reset();
    check("R1 ctl", ctl_q, 8'h08);
    check("R1 stat", stat_q, 8'hB0);
    check("R1 pins", pins(), 8'h08);
    check("R1 delta", {7'b0, delta_o}, 8'h00);
  endtask

  task automatic t_ctl();
    write_ctl(8'hE5);
    check("R2 mask", ctl_q, 8'h05);
    check("R3 pins", pins(), 8'h05);
    write_ctl(8'h0A);
    check("R2 write", ctl_q, 8'h0A);
    check("R3 pins2", pins(), 8'h0A);
  endtask

  task automatic t_lines();
    dcd_i = 0; step();
    check("R4/R5 dcd fall", stat_q, 8'h38);
    check("R11 delta", {7'b0, delta_o}, 8'h01);
    dsr_i = 0; step();
    check("R5 dsr sticky", stat_q, 8'h1A);
    cts_i = 0; step();
    check("R5 cts", stat_q, 8'h0B);
    read_stat();
    check("R7 clear", stat_q, 8'h00);
    check("R11 clear", {7'b0, delta_o}, 8'h00);
    cts_i = 1; dcd_i = 1; step();
    check("R5 rise", stat_q, 8'h99);
    read_stat();
    check("R7 upper kept", stat_q, 8'h90);
  endtask

  task automatic t_ring();
    ri_i = 1; step();
    check("R6 rise no flag", stat_q, 8'hD0);
    ri_i = 0; step();
    check("R6 fall flag", stat_q, 8'h94);
    read_stat();
  endtask

  task automatic t_collide();
    dsr_i = 1; step();
    check("R5 dsr set", stat_q, 8'hB2);
    stat_rd = 1; cts_i = 0;
    step();
    stat_rd = 0;
    check("R8 new flag kept", stat_q, 8'hA1);
    read_stat();
    check("R7 clear2", stat_q, 8'hA0);
  endtask

  task automatic t_loop();
    // lines now dcd=1 ri=0 dsr=1 cts=0
    write_ctl(8'h19);
    check("R10 pins idle", pins(), 8'h00);
    step();
    check("R9 map", stat_q[7:4], 8'h0A);
    read_stat();
    cts_i = 1; dcd_i = 0; ri_i = 1; dsr_i = 0;
    step(); step();
    check("R9 ignore ext", stat_q, 8'hA0);
    write_ctl(8'h14);
    step();
    check("R9 ri rise", stat_q, 8'h4A);
    check("R10 pins idle2", pins(), 8'h00);
    read_stat();
    write_ctl(8'h12);
    step();
    check("R9/R6 ri fall", stat_q, 8'h15);
    read_stat();
    write_ctl(8'h00);
    check("R3 exit loop", pins(), 8'h00);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctl();
    t_lines();
    t_ring();
    t_collide();
    t_loop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule